// File: doc/BRIEF.md
# USB Supply Detect Sequencer

This block watches a debounced level that says whether the USB bus supply is inside its valid window. It turns the edges of that level into single-cycle software events and drives the enable of the on-chip USB regulator. After the regulator is switched on, it counts a fixed settling interval in clock cycles and then reports that the supply output is ready. The analog comparators, the regulator itself and the bus pull-up are handled elsewhere.

Each event also sets a sticky flag, and software clears that flag by writing zero to it. A three-bit interrupt mask is changed through a set port and a clear port, each written with ones. A single interrupt line is the OR of the flags whose mask bit is set. While the system is powered off, a bus supply that becomes valid raises a wake request and records the bus supply as the wake cause. The block is driven through a small select/write/read register port.

Top module: `usb_supply_seq`

## Requirements
- R1: After reset, every event output, the regulator enable, both status bits, the interrupt line, the wake request, the wake cause and the whole mask are 0, and every readable register reads 0.
- R2: When `vbus_valid_i` is sampled high at a rising clock edge after being sampled low at the edge before, `ev_detect_o` is high for exactly the one cycle that follows that edge.
- R3: When `vbus_valid_i` is sampled low after being sampled high at the edge before, `ev_removed_o` is high for exactly the one following cycle.
- R4: `reg_en_o` is high in the cycle after an edge where `usb_en_i` and `vbus_valid_i` were both sampled high, and low otherwise.
- R5: If the regulator enable stays high for SETTLE_CYCLES edges after its rising edge, then `status_o[1]` rises at that edge and `ev_ready_o` pulses for that one cycle. The ready bit then stays high while the enable holds.
- R6: If the regulator enable drops before settling ends, the count is abandoned and no ready event occurs; a later enable starts a full new interval. The ready bit clears at the same edge where the enable drops.
- R7: The status register (select 0) reads bus-supply-present at bit 0 and output-ready at bit 1, mirroring `status_o`. Writes to it change nothing. Unused selects 2 and 3 read 0.
- R8: The interrupt mask sits at bits 7 (detect), 8 (removed) and 9 (ready) of select 1. Writing ones at those bits to select 2 sets them, and writing ones to select 3 clears them. Zeros written to either port, and any write to select 1, leave the mask unchanged.
- R9: The sticky flags for detect, removed and ready read at bit 0 of selects 4, 5 and 6. Each is set in the cycle after its event pulse. A write with bit 0 equal to 0 clears it, a write with bit 0 equal to 1 does nothing, and a set in the same cycle as a clear wins.
- R10: `irq_o` is high exactly when some sticky flag among detect, removed and ready is set while its mask bit is set.
- R11: If the bus supply becomes valid (as in R2) while `sys_off_i` is high, `wake_req_o` rises at that edge. It stays high until an edge samples `sys_off_i` low. The wake cause flag (`wake_vbus_o`, bit 0 of select 7) sets one cycle later and is cleared only by writing 0 at bit 0 of select 7. A rise while `sys_off_i` is low produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbus_valid_i | input | 1 | Debounced bus-supply-in-range level |
| usb_en_i | input | 1 | USB peripheral enable |
| sys_off_i | input | 1 | System is in its powered-off state |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| ev_detect_o | output | 1 | Supply-detected event pulse |
| ev_removed_o | output | 1 | Supply-removed event pulse |
| ev_ready_o | output | 1 | Regulator-settled event pulse |
| reg_en_o | output | 1 | USB regulator enable |
| status_o | output | 2 | Bit 0 supply present, bit 1 output ready |
| irq_o | output | 1 | Interrupt line |
| wake_req_o | output | 1 | Wake request from the off state |
| wake_vbus_o | output | 1 | Sticky bus-supply wake cause |

## Verification
The bench runs long random stretches in which the supply level toggles rarely. In those stretches the enable often survives the whole settling interval, so completed ready sequences are distinguished from runs that are cut short. Short enable bursts are mixed in, and these separate an abandoned count from one that only pauses. Random writes over all eight selects, with varied bit 0 and mask bits, tell clear-by-zero apart from write-one and from writes to the wrong port. They also exercise the set-beats-clear case. Toggling the off indication around supply rises separates woken rises from ordinary ones.

// File: rtl/usb_seq_pkg.sv
package usb_seq_pkg;
   typedef enum logic [2:0] {
      SEL_STATUS   = 3'd0,
      SEL_INTEN    = 3'd1,
      SEL_INTSET   = 3'd2,
      SEL_INTCLR   = 3'd3,
      SEL_FLAG_DET = 3'd4,
      SEL_FLAG_REM = 3'd5,
      SEL_FLAG_RDY = 3'd6,
      SEL_WAKE     = 3'd7
   } reg_sel_e;

   // Event / flag indices; flag k is read at select 4+k.
   localparam int EV_DET  = 0;
   localparam int EV_REM  = 1;
   localparam int EV_RDY  = 2;
   localparam int EV_WAKE = 3;
   localparam int NUM_IRQ_EV = 3;
   localparam int NUM_FLAGS  = 4;

   localparam int IE_LSB      = 7;
   localparam int ST_VBUS_BIT = 0;
   localparam int ST_RDY_BIT  = 1;
endpackage

// File: rtl/usb_vbus_edge.sv
module usb_vbus_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic vbus_valid_i,
   input  logic sys_off_i,
   output logic vbus_q_o,
   output logic ev_det_o,
   output logic ev_rem_o,
   output logic wake_req_o,
   output logic wake_set_o
);
   logic rise, fall;

   assign rise = vbus_valid_i & ~vbus_q_o;
   assign fall = ~vbus_valid_i & vbus_q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbus_q_o   <= 1'b0;
         ev_det_o   <= 1'b0;
         ev_rem_o   <= 1'b0;
         wake_req_o <= 1'b0;
         wake_set_o <= 1'b0;
      end else begin
         vbus_q_o   <= vbus_valid_i;
         ev_det_o   <= rise;
         ev_rem_o   <= fall;
         wake_req_o <= sys_off_i & (wake_req_o | rise);
         wake_set_o <= sys_off_i & rise;
      end
   end

   p_detect_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_det_o |=> !ev_det_o);
   p_detect_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_det_o |-> (vbus_q_o && !$past(vbus_q_o)));
   p_removed_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rem_o |-> (!vbus_q_o && $past(vbus_q_o)));
   p_wake_needs_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req_o |-> $past(sys_off_i));
endmodule

// File: rtl/usb_settle_timer.sv
module usb_settle_timer #(
   parameter int SETTLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic usb_en_i,
   input  logic vbus_valid_i,
   output logic reg_en_o,
   output logic ready_o,
   output logic ev_ready_o
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end

   logic             en_next;
   logic [CNT_W-1:0] cnt;

   assign en_next = usb_en_i & vbus_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_en_o   <= 1'b0;
         ready_o    <= 1'b0;
         ev_ready_o <= 1'b0;
         cnt        <= '0;
      end else begin
         reg_en_o   <= en_next;
         ev_ready_o <= 1'b0;
         if (!en_next) begin
            cnt     <= '0;
            ready_o <= 1'b0;
         end else if (reg_en_o && !ready_o) begin
            if (cnt == LAST) begin
               cnt        <= '0;
               ready_o    <= 1'b1;
               ev_ready_o <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_ready_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> reg_en_o);
   p_ready_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready_o |-> (ready_o && !$past(ready_o)));
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_en_o) |-> !ready_o);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
   import usb_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [2:0]            sel_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [NUM_FLAGS-1:0]  ev_i,
   input  logic [1:0]            status_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic [NUM_FLAGS-1:0]  flags_o,
   output logic                  irq_o
);
   reg_sel_e                sel;
   logic [NUM_IRQ_EV-1:0]   inten;
   logic [NUM_IRQ_EV-1:0]   wmask;

   assign sel   = reg_sel_e'(sel_i);
   assign wmask = wdata_i[IE_LSB +: NUM_IRQ_EV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inten <= '0;
      end else if (wr_i && sel == SEL_INTSET) begin
         inten <= inten | wmask;
      end else if (wr_i && sel == SEL_INTCLR) begin
         inten <= inten & ~wmask;
      end
   end

   for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
      logic clr;
      assign clr = wr_i && sel_i[2] && (sel_i[1:0] == 2'(k)) && !wdata_i[0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags_o[k] <= 1'b0;
         else if (ev_i[k]) flags_o[k] <= 1'b1;
         else if (clr)     flags_o[k] <= 1'b0;
      end
      p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ev_i[k] |=> flags_o[k]);
   end

   assign irq_o = |(flags_o[NUM_IRQ_EV-1:0] & inten);

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_STATUS: rdata_o[1:0] = status_i;
         SEL_INTEN:  rdata_o[IE_LSB +: NUM_IRQ_EV] = inten;
         SEL_FLAG_DET, SEL_FLAG_REM, SEL_FLAG_RDY, SEL_WAKE:
            rdata_o[0] = flags_o[sel_i[1:0]];
         default:    rdata_o = '0;
      endcase
   end

   p_inten_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == SEL_INTCLR && wdata_i[IE_LSB]) |=> !inten[0]);
   p_inten_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == SEL_INTSET && wdata_i[IE_LSB+2]) |=> inten[2]);
   p_inten_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && (sel == SEL_INTSET || sel == SEL_INTCLR)) |=> $stable(inten));
endmodule

// File: rtl/usb_supply_seq.sv
module usb_supply_seq
   import usb_seq_pkg::*;
#(
   parameter int SETTLE_CYCLES = 16,
   parameter int DATA_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vbus_valid_i,
   input  logic              usb_en_i,
   input  logic              sys_off_i,
   input  logic              reg_wr_i,
   input  logic [2:0]        reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              ev_detect_o,
   output logic              ev_removed_o,
   output logic              ev_ready_o,
   output logic              reg_en_o,
   output logic [1:0]        status_o,
   output logic              irq_o,
   output logic              wake_req_o,
   output logic              wake_vbus_o
);
   if (DATA_W < IE_LSB + NUM_IRQ_EV) begin : g_bad_width
      $error("DATA_W too narrow for the interrupt mask field");
   end

   logic                 vbus_q, ready, wake_set;
   logic [NUM_FLAGS-1:0] ev_vec, flags;

   usb_vbus_edge u_edge (
      .clk          (clk),
      .rst_n        (rst_n),
      .vbus_valid_i (vbus_valid_i),
      .sys_off_i    (sys_off_i),
      .vbus_q_o     (vbus_q),
      .ev_det_o     (ev_detect_o),
      .ev_rem_o     (ev_removed_o),
      .wake_req_o   (wake_req_o),
      .wake_set_o   (wake_set)
   );

   usb_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .usb_en_i     (usb_en_i),
      .vbus_valid_i (vbus_valid_i),
      .reg_en_o     (reg_en_o),
      .ready_o      (ready),
      .ev_ready_o   (ev_ready_o)
   );

   assign status_o[ST_VBUS_BIT] = vbus_q;
   assign status_o[ST_RDY_BIT]  = ready;

   always_comb begin
      ev_vec          = '0;
      ev_vec[EV_DET]  = ev_detect_o;
      ev_vec[EV_REM]  = ev_removed_o;
      ev_vec[EV_RDY]  = ev_ready_o;
      ev_vec[EV_WAKE] = wake_set;
   end

   usb_irq_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr_i),
      .sel_i    (reg_sel_i),
      .wdata_i  (reg_wdata_i),
      .ev_i     (ev_vec),
      .status_i (status_o),
      .rdata_o  (reg_rdata_o),
      .flags_o  (flags),
      .irq_o    (irq_o)
   );

   assign wake_vbus_o = flags[EV_WAKE];

   p_regen_needs_vbus_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en_o |-> status_o[ST_VBUS_BIT]);
   p_events_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_detect_o && ev_removed_o));
   p_wake_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req_o) |=> wake_vbus_o);
endmodule

// File: tb/tb_usb_supply_seq.sv
module tb_usb_supply_seq;
   localparam int S  = 16;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vbus = 0, en = 0, off = 0, wr = 0;
   logic [2:0] sel = 3'd0;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rdata;
   logic evd, evr, evy, regen, irq, wreq, wvbus;
   logic [1:0] status;

   always #10 clk = ~clk;

   usb_supply_seq #(.SETTLE_CYCLES(S), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .vbus_valid_i(vbus), .usb_en_i(en),
      .sys_off_i(off), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wd),
      .reg_rdata_o(rdata), .ev_detect_o(evd), .ev_removed_o(evr),
      .ev_ready_o(evy), .reg_en_o(regen), .status_o(status), .irq_o(irq),
      .wake_req_o(wreq), .wake_vbus_o(wvbus));

   int checks = 0, fails = 0;
   bit done = 0;

   // reference state
   logic m_vbus, m_evd, m_evr, m_ws, m_wake, m_regen, m_rdy, m_evy;
   int   m_cnt;
   logic [2:0] m_ie;
   logic [3:0] m_fl;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_vbus = 0; m_evd = 0; m_evr = 0; m_ws = 0; m_wake = 0;
      m_regen = 0; m_rdy = 0; m_evy = 0; m_cnt = 0; m_ie = '0; m_fl = '0;
   endtask

   task automatic model_step();
      logic [3:0] old_ev;
      logic rise, fall, en_next;
      old_ev  = {m_ws, m_evy, m_evr, m_evd};
      rise    = vbus & ~m_vbus;
      fall    = ~vbus & m_vbus;
      en_next = en & vbus;
      m_evy = 0;
      if (!en_next) begin
         m_cnt = 0; m_rdy = 0;
      end else if (m_regen && !m_rdy) begin
         if (m_cnt == S - 1) begin m_cnt = 0; m_rdy = 1; m_evy = 1; end
         else m_cnt++;
      end
      m_regen = en_next;
      m_wake  = off & (m_wake | rise);
      m_ws    = off & rise;
      m_evd   = rise;
      m_evr   = fall;
      m_vbus  = vbus;
      if (wr && sel == 3'd2) m_ie = m_ie | wd[9:7];
      if (wr && sel == 3'd3) m_ie = m_ie & ~wd[9:7];
      for (int k = 0; k < 4; k++) begin
         if (old_ev[k]) m_fl[k] = 1'b1;
         else if (wr && sel == 3'(4 + k) && !wd[0]) m_fl[k] = 1'b0;
      end
   endtask

   function automatic logic [DW-1:0] exp_rdata(input logic [2:0] s);
      logic [DW-1:0] r;
      r = '0;
      case (s)
         3'd0: r[1:0] = {m_rdy, m_vbus};
         3'd1: r[9:7] = m_ie;
         3'd4, 3'd5, 3'd6, 3'd7: r[0] = m_fl[s[1:0]];
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic compare_all();
      chk("R2 detect event", evd, m_evd);
      chk("R3 removed event", evr, m_evr);
      chk("R4 regulator enable", regen, m_regen);
      chk("R5 ready event", evy, m_evy);
      chk("R5 status ready bit", status[1], m_rdy);
      chk("R7 status present bit", status[0], m_vbus);
      chk("R10 interrupt line", irq, |(m_fl[2:0] & m_ie));
      chk("R11 wake request", wreq, m_wake);
      chk("R11 wake cause", wvbus, m_fl[3]);
      case (sel)
         3'd1:                chk("R8 mask read", rdata, exp_rdata(sel));
         3'd4, 3'd5, 3'd6:    chk("R9 flag read", rdata, exp_rdata(sel));
         3'd7:                chk("R11 cause read", rdata, exp_rdata(sel));
         default:             chk("R7 status/unused read", rdata, exp_rdata(sel));
      endcase
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wreg(input logic [2:0] s, input logic [DW-1:0] d);
      wr = 1; sel = s; wd = d;
      tick();
      wr = 0; wd = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 detect", evd, 0); chk("R1 removed", evr, 0); chk("R1 ready", evy, 0);
      chk("R1 regen", regen, 0); chk("R1 status", status, 0); chk("R1 irq", irq, 0);
      chk("R1 wake", wreq, 0); chk("R1 cause", wvbus, 0);
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s); #1; chk("R1 read zero", rdata, 0);
      end
      sel = 3'd0;
      rst_n = 1;
      tick();

      // directed: full settle sequence
      wreg(3'd2, 16'h0380);
      sel = 3'd1; tick(); chk("R8 mask set", rdata, 16'h0380);
      wreg(3'd1, 16'h0000);
      chk("R8 write to view ignored", rdata, 16'h0380);
      vbus = 1; en = 1; sel = 3'd0;
      tick(); chk("R2 detect pulse", evd, 1);
      for (int i = 0; i < S - 1; i++) tick();
      chk("R5 not yet ready", status[1], 0);
      tick(); chk("R5 ready at settle", evy, 1); chk("R5 status bit1", status[1], 1);
      wreg(3'd0, 16'hFFFF);
      chk("R7 status write ignored", rdata, 16'h0003);
      // R6: abort mid-settle
      en = 0; tick(); chk("R6 ready clears with enable", status[1], 0);
      en = 1; repeat (5) tick();
      en = 0; tick();
      en = 1;
      for (int i = 0; i < S; i++) begin
         tick(); chk("R6 fresh interval, no early ready", evy, 0);
      end
      tick(); chk("R6 ready after fresh interval", evy, 1);
      // R9: write 1 keeps, write 0 clears
      wreg(3'd6, 16'h0001); sel = 3'd6; tick(); chk("R9 write one keeps", rdata, 1);
      wreg(3'd6, 16'h0000); sel = 3'd6; tick(); chk("R9 write zero clears", rdata, 0);
      // R11: wake from off
      vbus = 0; tick();
      off = 1; vbus = 1; tick(); chk("R11 wake raised", wreq, 1);
      tick(); chk("R11 cause set", wvbus, 1);
      off = 0; tick(); chk("R11 wake drops", wreq, 0);
      wreg(3'd7, 16'h0000); tick(); chk("R11 cause cleared", wvbus, 0);
      // R3 + R8 clear
      wreg(3'd3, 16'h0080);
      vbus = 0; tick(); chk("R3 removed pulse", evr, 1);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 29) == 0) vbus = ~vbus;
         if ($urandom_range(0, 49) == 0) en = ~en;
         if ($urandom_range(0, 39) == 0) off = ~off;
         wr  = ($urandom_range(0, 5) == 0);
         sel = 3'($urandom_range(0, 7));
         wd  = DW'($urandom);
         tick();
      end
      wr = 0;
      finish_run();
   end
endmodule